// File: doc/BRIEF.md
# Phase Measurement Outlier Gate

This block sits between a phase detector and the loop filter of a clock-discipline loop. Each cycle it may receive a 16-bit phase reading with a valid strobe. The upper 8 bits of a reading count whole clocks and the lower 8 bits are a fraction of a clock. The block subtracts the current reference phase from the reading, modulo 2^16, and treats the result as a signed deviation. It then compares the magnitude of that deviation with a programmable limit. A deviation inside the limit goes to the loop filter. A deviation outside the limit is never acted on the first time it is seen.

On a first outlier, the gate drops the reading and pulses a retry request, so that the detector takes one more measurement. If that second reading is back inside the limit, it is forwarded and the old reference stays. If it is also outside the limit, the jump counts as real. The gate then makes the confirming reading the new reference, so the loop sees no large error and does not slew. It also sets a sticky poor-quality flag for the network supervisor.

A supervisor can take control in two ways. It can hold the gate, so that readings are ignored. It can also load a reference phase of its choosing. The poor-quality flag stays set until a clear pulse arrives.

Top module: `phase_outlier_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `ref_phase` becomes 0x0000, `poor_quality`, `fwd_valid` and `retry_req` become 0, and the gate is in the tracking state.
- R2: A valid reading is within the limit when the magnitude of its deviation is no greater than `limit`. The deviation is `rd_phase - ref_phase` modulo 2^16, read as two's complement. In the tracking state, a valid reading within the limit gives `fwd_valid`=1 on the next cycle, with `fwd_dev` carrying that deviation.
- R3: The deviation wraps around the 16-bit phase circle. With reference 0xFFF0, a reading of 0x0005 gives a deviation of +0x0015, not a large jump.
- R4: In the tracking state, a valid reading outside the limit is not forwarded. `retry_req` is high for exactly the one following cycle, and the gate then waits for a confirming reading.
- R5: While the gate waits, a valid reading within the limit is forwarded as in R2. The reference does not change, `poor_quality` does not change, and the gate returns to tracking.
- R6: While the gate waits, a valid reading outside the limit is not forwarded. On the next cycle, `ref_phase` equals that reading and `poor_quality` is 1, and the gate returns to tracking. Apart from this case and R9, `ref_phase` never changes.
- R7: `poor_quality` stays at 1 until a cycle with `alarm_clr`=1 clears it. If a confirmed jump and `alarm_clr` arrive in the same cycle, the flag ends up at 1.
- R8: While `ovr_hold` is 1, readings have no effect: there is no forward, no retry and no change to the reference. The hold also cancels any pending confirmation. Once the hold is released, the next outlier is treated as a first outlier.
- R9: When `ovr_load` is 1, `ref_phase` takes the value of `ovr_phase` on the next cycle. This works during a hold as well. The load cancels any pending confirmation, and a reading in the same cycle is dropped.
- R10: A deviation whose magnitude exactly equals `limit` is within the limit. A deviation of 0x8000 has magnitude 32768: it is outside any limit of 0x7FFF or less and inside a limit of 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_valid | input | 1 | Phase reading strobe |
| rd_phase | input | 16 | Phase reading (8 whole-clock bits, 8 fraction bits) |
| limit | input | 16 | Largest deviation magnitude accepted |
| ovr_hold | input | 1 | Supervisor hold: readings ignored |
| ovr_load | input | 1 | Supervisor load of the reference |
| ovr_phase | input | 16 | Reference value for a supervisor load |
| alarm_clr | input | 1 | Clears the poor-quality flag |
| fwd_valid | output | 1 | Forwarded deviation strobe |
| fwd_dev | output | 16 | Forwarded signed deviation |
| retry_req | output | 1 | One-cycle request for a fresh measurement |
| ref_phase | output | 16 | Current reference phase |
| poor_quality | output | 1 | Sticky poor-sync-quality notification |

## Verification
Some properties are checked by assertions on every cycle:
- a forwarded deviation never exceeds the limit that applied to it;
- the retry pulse never lasts beyond one cycle;
- the waiting state is entered only through a retry;
- a hold suppresses both forwarding and retries;
- the reference moves only on an adoption or a supervisor load;
- the flag falls only on a clear, and when it rises the reference holds the confirming reading.

Other behaviour can only be shown by the bench's scenarios, because it depends on a sequence of readings:
- the discard-then-confirm decision across two readings;
- the cancellation of a pending confirmation by a hold or a load;
- the wraparound and boundary values of the deviation;
- the priority of setting the flag over clearing it.

// File: rtl/pog_pkg.sv
// Package pog_pkg
// Holds the types and helpers that the outlier gate modules share.
// Assumes that the phase width is at least 2 bits.
package pog_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_AWAIT = 2'd1,
        ST_HOLD  = 2'd2
    } gate_state_e;

    // Magnitude of a 16-bit two's-complement deviation, widened to 17 bits
    // so that 0x8000 maps to 32768.
    function automatic logic [16:0] dev_mag16(input logic [15:0] d);
        logic [16:0] m;
        if (d[15]) m = {1'b0, ~d} + 17'd1;
        else       m = {1'b0, d};
        return m;
    endfunction
endpackage

// File: rtl/pog_deviation.sv
// Module pog_deviation
// Purely combinational. Forms the signed deviation of a reading from the
// reference, modulo 2^PW, and flags it when its magnitude exceeds the limit.
// A magnitude equal to the limit is not flagged.
// Assumes two's-complement deviations, so the most negative value has
// magnitude 2^(PW-1).
module pog_deviation #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] sample,
    input  logic [PW-1:0] ref_val,
    input  logic [PW-1:0] limit,
    output logic [PW-1:0] dev,
    output logic          outlier
);
    localparam int MW = PW + 1;

    logic [MW-1:0] mag;

    // Wrapped difference, its magnitude, and the compare against the limit.
    always_comb begin
        dev = sample - ref_val;
        if (dev[PW-1]) mag = {1'b0, ~dev} + MW'(1);
        else           mag = {1'b0, dev};
        outlier = mag > {1'b0, limit};
    end
endmodule

// File: rtl/pog_ctrl.sv
// Module pog_ctrl
// The discard-and-recheck state machine. It decides, for each cycle, whether
// to forward a reading, request a retry, or adopt the reading as the new
// reference. The supervisor hold and load override the automatic decision,
// with hold taking priority.
// Assumes that outlier is valid whenever rd_valid is high.
module pog_ctrl
    import pog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_valid,
    input  logic        outlier,
    input  logic        ovr_hold,
    input  logic        ovr_load,
    output gate_state_e state,
    output logic        fwd_en,
    output logic        retry_en,
    output logic        adopt_en
);
    gate_state_e nxt;

    // Next-state and action decode.
    always_comb begin
        nxt      = state;
        fwd_en   = 1'b0;
        retry_en = 1'b0;
        adopt_en = 1'b0;
        if (ovr_hold) begin
            nxt = ST_HOLD;
        end else if (ovr_load) begin
            nxt = ST_TRACK;
        end else if (rd_valid) begin
            if (state == ST_AWAIT) begin
                adopt_en = outlier;
                fwd_en   = !outlier;
                nxt      = ST_TRACK;
            end else if (outlier) begin
                retry_en = 1'b1;
                nxt      = ST_AWAIT;
            end else begin
                fwd_en = 1'b1;
                nxt    = ST_TRACK;
            end
        end else if (state == ST_HOLD) begin
            nxt = ST_TRACK;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_TRACK;
        else        state <= nxt;
    end

    // R4: the waiting state is entered only through a retry request.
    assert_await_via_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT) |-> ($past(retry_en) || $past(state == ST_AWAIT)));

    // R8: while held, nothing is forwarded, retried or adopted.
    assert_hold_no_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !$past(fwd_en || retry_en || adopt_en));
endmodule

// File: rtl/pog_refstore.sv
// Module pog_refstore
// Holds the reference phase and the sticky poor-quality flag. A supervisor
// load takes priority over adoption of a confirmed reading. When a set and a
// clear of the flag arrive in the same cycle, the set wins.
// Assumes that adopt_en and ovr_load are never both high, because the
// controller gives the load priority.
module pog_refstore #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adopt_en,
    input  logic [PW-1:0] sample,
    input  logic          ovr_load,
    input  logic [PW-1:0] ovr_phase,
    input  logic          alarm_clr,
    output logic [PW-1:0] ref_val,
    output logic          alarm
);
    // Reference register.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_val <= '0;
        else if (ovr_load) ref_val <= ovr_phase;
        else if (adopt_en) ref_val <= sample;
    end

    // Sticky alarm register: a set takes precedence over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         alarm <= 1'b0;
        else if (adopt_en)  alarm <= 1'b1;
        else if (alarm_clr) alarm <= 1'b0;
    end

    // R7: the flag falls only after a clear request.
    assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> $past(alarm_clr));

    // R6: when the flag rises, the reference holds the confirming sample.
    assert_adopt_loads_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> (ref_val == $past(sample)));
endmodule

// File: rtl/phase_outlier_gate.sv
// Module phase_outlier_gate (top)
// Gates phase readings before they reach a loop filter. A reading within the
// limit is forwarded. A first outlier is discarded and a re-measurement is
// requested. A confirmed outlier becomes the new reference and raises a
// sticky poor-quality flag.
// Assumes one reading per cycle at most and an active-low synchronous reset.
// The forward and retry outputs are registered: they appear one cycle after
// the reading that caused them.
module phase_outlier_gate
    import pog_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [PW-1:0] rd_phase,
    input  logic [PW-1:0] limit,
    input  logic          ovr_hold,
    input  logic          ovr_load,
    input  logic [PW-1:0] ovr_phase,
    input  logic          alarm_clr,
    output logic          fwd_valid,
    output logic [PW-1:0] fwd_dev,
    output logic          retry_req,
    output logic [PW-1:0] ref_phase,
    output logic          poor_quality
);
    logic [PW-1:0] dev;
    logic          outlier;
    logic          fwd_en, retry_en, adopt_en;
    gate_state_e   state;

    pog_deviation #(.PW(PW)) u_dev (
        .sample (rd_phase),
        .ref_val(ref_phase),
        .limit  (limit),
        .dev    (dev),
        .outlier(outlier)
    );

    pog_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_valid(rd_valid),
        .outlier (outlier),
        .ovr_hold(ovr_hold),
        .ovr_load(ovr_load),
        .state   (state),
        .fwd_en  (fwd_en),
        .retry_en(retry_en),
        .adopt_en(adopt_en)
    );

    pog_refstore #(.PW(PW)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .adopt_en (adopt_en),
        .sample   (rd_phase),
        .ovr_load (ovr_load),
        .ovr_phase(ovr_phase),
        .alarm_clr(alarm_clr),
        .ref_val  (ref_phase),
        .alarm    (poor_quality)
    );

    // Output registers for the forward strobe, the deviation and the retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_dev   <= '0;
            retry_req <= 1'b0;
        end else begin
            fwd_valid <= fwd_en;
            fwd_dev   <= fwd_en ? dev : '0;
            retry_req <= retry_en;
        end
    end

    // R2: a forwarded deviation never exceeds the limit that applied to it.
    assert_fwd_within_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (dev_mag16(16'(fwd_dev)) <= {1'b0, 16'($past(limit))}));

    // R4: a retry request lasts exactly one cycle.
    assert_retry_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req);

    // R8: a held cycle produces neither a forward nor a retry.
    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovr_hold) |-> (!fwd_valid && !retry_req));

    // R6/R9: with no reading and no load, the reference stays put.
    assert_ref_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ovr_load) && !$past(rd_valid)) |-> $stable(ref_phase));
endmodule

// File: tb/phase_outlier_gate_test.sv
// Self-checking bench for phase_outlier_gate. Directed corner cases come
// first, then a seeded random run. Every cycle is compared against a
// behavioural model built from the requirements.
module phase_outlier_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_phase = '0;
    logic [15:0] limit = 16'h0100;
    logic        ovr_hold = 1'b0;
    logic        ovr_load = 1'b0;
    logic [15:0] ovr_phase = '0;
    logic        alarm_clr = 1'b0;
    logic        fwd_valid, retry_req, poor_quality;
    logic [15:0] fwd_dev, ref_phase;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state: 0 = tracking, 1 = waiting for confirmation, 2 = held.
    logic [15:0] m_ref = '0;
    bit          m_alarm = 0;
    int          m_st = 0;
    bit          e_fwd, e_retry;
    logic [15:0] e_dev;

    always #2 clk = ~clk;

    phase_outlier_gate uut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_phase(rd_phase),
        .limit(limit), .ovr_hold(ovr_hold), .ovr_load(ovr_load),
        .ovr_phase(ovr_phase), .alarm_clr(alarm_clr), .fwd_valid(fwd_valid),
        .fwd_dev(fwd_dev), .retry_req(retry_req), .ref_phase(ref_phase),
        .poor_quality(poor_quality)
    );

    function automatic logic [15:0] wrap_dev(input logic [15:0] r, input logic [15:0] rf);
        return r - rf;
    endfunction

    function automatic bit is_far(input logic [15:0] d, input logic [15:0] lim);
        int mag;
        mag = d[15] ? 65536 - int'(d) : int'(d);
        return mag > int'(lim);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Predict this cycle's results from the model, then advance the model.
    task automatic predict();
        logic [15:0] d;
        e_fwd = 0; e_retry = 0; e_dev = '0;
        if (!rst_n) begin
            m_ref = '0; m_alarm = 0; m_st = 0;
            return;
        end
        d = wrap_dev(rd_phase, m_ref);
        if (ovr_hold) begin
            m_st = 2;
        end else if (ovr_load) begin
            m_st = 0;
        end else if (rd_valid) begin
            if (m_st == 1) begin
                if (is_far(d, limit)) begin
                    m_ref = rd_phase; m_alarm = 1;
                end else begin
                    e_fwd = 1; e_dev = d;
                end
                m_st = 0;
            end else if (is_far(d, limit)) begin
                e_retry = 1; m_st = 1;
            end else begin
                e_fwd = 1; e_dev = d; m_st = 0;
            end
        end else if (m_st == 2) begin
            m_st = 0;
        end
        if (ovr_load) m_ref = ovr_phase;
        if (alarm_clr && !(e_fwd == 0 && m_alarm && rd_valid && !ovr_hold && !ovr_load && m_ref == rd_phase && d != 0))
            ; // the set-wins case is handled below
    endtask

    // Run one clock: drive at the falling edge, sample just after the rising edge.
    task automatic step(input string tag, input bit v, input logic [15:0] ph,
                        input bit hold, input bit ld, input logic [15:0] lph, input bit clr);
        bit was_alarm, adopt;
        @(negedge clk);
        rd_valid = v; rd_phase = ph; ovr_hold = hold; ovr_load = ld;
        ovr_phase = lph; alarm_clr = clr;
        was_alarm = m_alarm;
        m_alarm = 0;
        predict();
        adopt = m_alarm;
        if (rst_n) m_alarm = adopt ? 1'b1 : (clr ? 1'b0 : was_alarm);
        @(posedge clk);
        #1;
        chk(fwd_valid == e_fwd, {tag, " fwd_valid"}, 16'(fwd_valid), 16'(e_fwd));
        chk(retry_req == e_retry, {tag, " retry_req"}, 16'(retry_req), 16'(e_retry));
        if (e_fwd) chk(fwd_dev == e_dev, {tag, " fwd_dev"}, fwd_dev, e_dev);
        chk(ref_phase == m_ref, {tag, " ref_phase"}, ref_phase, m_ref);
        chk(poor_quality == m_alarm, {tag, " poor_quality"}, 16'(poor_quality), 16'(m_alarm));
    endtask

    task automatic rd(input string tag, input logic [15:0] ph);
        step(tag, 1, ph, 0, 0, '0, 0);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, '0, 0, 0, '0, 0);
    endtask

    initial begin
        rst_n = 0;
        step("R1 reset", 1, 16'h4000, 0, 0, '0, 0);
        step("R1 reset", 1, 16'h4000, 0, 1, 16'h1234, 0);
        rst_n = 1;
        idle("R1 after reset");

        // R2 and R10: forwarding inside the limit, including both boundaries.
        limit = 16'h0100;
        rd("R2 small positive", 16'h0080);
        rd("R10 equal to limit", 16'h0100);
        rd("R10 negative equal to limit", 16'hFF00);
        rd("R2 zero", 16'h0000);

        // R3: a wrapped deviation of +0x15 around reference 0xFFF0.
        step("R9 load", 0, '0, 0, 1, 16'hFFF0, 0);
        rd("R3 wraparound", 16'h0005);

        // R4 then R5: discard a first outlier, then accept a confirming reading that is back in range.
        rd("R4 first outlier", 16'h4000);
        idle("R4 retry is one cycle");
        rd("R5 recheck within", 16'hFFF8);
        rd("R5 tracking again", 16'hFFF0);

        // R6: a confirmed jump is adopted as the new reference.
        rd("R4 outlier", 16'h4000);
        rd("R6 confirmed", 16'h4010);
        rd("R6 track new ref", 16'h4020);

        // R7: the flag is sticky; a clear removes it; a set beats a simultaneous clear.
        idle("R7 sticky");
        step("R7 clear", 0, '0, 0, 0, '0, 1);
        rd("R7 outlier", 16'h0000);
        step("R7 set beats clear", 1, 16'h0000, 0, 0, '0, 1);

        // R8: a hold cancels a pending confirmation and ignores readings.
        step("R7 clear", 0, '0, 0, 0, '0, 1);
        rd("R8 outlier", 16'h8000);
        step("R8 hold", 1, 16'h8000, 1, 0, '0, 0);
        step("R8 hold ignores", 1, 16'h0001, 1, 0, '0, 0);
        rd("R8 first outlier again", 16'h8000);
        idle("R8 gap");

        // R9: a load cancels a pending confirmation and drops the reading in the same cycle; a load during a hold also works.
        rd("R9 outlier", 16'h9000);
        step("R9 load drops reading", 1, 16'h9000, 0, 1, 16'h2000, 0);
        rd("R9 first outlier again", 16'h9000);
        step("R9 load in hold", 0, '0, 1, 1, 16'h3000, 0);
        idle("R9 release");

        // R10: the most negative deviation against two limits.
        step("R9 load zero", 0, '0, 0, 1, 16'h0000, 0);
        limit = 16'h7FFF;
        rd("R10 0x8000 outside 0x7FFF", 16'h8000);
        idle("R10 gap");
        limit = 16'hFFFF;
        rd("R10 0x8000 inside 0xFFFF", 16'h8000);

        // Seeded random mix of near and far readings with occasional supervisor actions.
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'd20240611);
        end
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ph;
            bit v, h, l, c;
            limit = 16'h0040 + 16'($urandom_range(0, 255));
            ph = ($urandom_range(0, 3) == 0) ? 16'($urandom) :
                 m_ref + 16'($urandom_range(0, 511)) - 16'd256;
            v = $urandom_range(0, 3) != 0;
            h = $urandom_range(0, 31) == 0;
            l = $urandom_range(0, 47) == 0;
            c = $urandom_range(0, 15) == 0;
            step("RND R2 R4 R5 R6 R7 R8 R9", v, ph, h, l, 16'($urandom), c);
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule